// File: doc/BRIEF.md
# Coincident-Edge Sync Pulse Generator

The block divides one fast source clock into two slower clocks, `qa_o` and `qc_o`, whose divide ratios need not be integer multiples of each other. It also drives an active-low marker, `sync_no`, that announces each rising edge the two divided clocks share. The marker goes low for exactly one period of the faster divided clock. That period ends on the shared edge, so the marker's rising edge lands on a rising edge of both clocks. Downstream logic that crosses between the two clock domains uses this rising edge as its safe transfer point.

Both divide ratios are taken only on a shared edge. Both divided clocks therefore restart their count together, and a change cannot produce a runt, a stretched period or a partial marker pulse. The marker has its own enable, and that enable is also taken only on a shared edge. When the ratios are equal, every edge is shared. In that case the marker alternates: low for one period, then high for one period.

Top module: `coin_sync_gen`

## Requirements
- R1: A divided clock of ratio N (counted in source cycles) is high for the first floor(N/2) source cycles of each N-cycle period and low for the rest. A ratio input below 2 is treated as 2.
- R2: With unequal ratios, `sync_no` is low for exactly the last period of the faster divided clock before each shared rising edge, and high in every other cycle.
- R3: `sync_no` rises only in a cycle where both `qa_o` and `qc_o` start a new period together.
- R4: With equal ratios, `sync_no` alternates period by period. The first period after reset or after a realignment to equal ratios continues the alternation. It counts shared edges from reset, with the first shared edge after reset giving a high period.
- R5: `div_a_i` and `div_c_i` are sampled only in a shared-edge cycle, and both counts restart from zero there. Ratio changes at any other time have no effect until the next shared edge.
- R6: `sync_en_i` is sampled only in a shared-edge cycle. While the sampled value is 0, `sync_no` stays high.
- R7: During reset, and with `sync_en_i` low, `sync_no` is high. The first cycle after reset is a shared-edge cycle with both divided clocks high.
- R8: Every ratio pair is handled, including 1:1, 2:1, 3:1, 3:2, 4:1, 4:3, 6:1, odd ratios, and the faster clock on either side.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Source clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| div_a_i | input | DIV_W | Divide ratio for `qa_o` |
| div_c_i | input | DIV_W | Divide ratio for `qc_o` |
| sync_en_i | input | 1 | Marker enable, 0 freezes `sync_no` high |
| qa_o | output | 1 | First divided clock |
| qc_o | output | 1 | Second divided clock |
| sync_no | output | 1 | Active-low marker ahead of each shared edge |

## Verification
Three events can fall in the same cycle: the end of a marker pulse, the shared edge, and the sampling of new ratios and of the enable. The bench provokes this by changing the ratios and toggling the enable at arbitrary cycles, including inside a marker pulse. A behavioural model works from the least common multiple of the ratios and predicts every output cycle by cycle. A mismatch in the cycle where all three events meet shows up as a clipped pulse or an early ratio change.

// File: rtl/sg_pkg.sv
package sg_pkg;
  localparam int MIN_DIV = 2;
  localparam int N_CLK   = 2;
endpackage

// File: rtl/sg_divider.sv
module sg_divider #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             load_i,
  input  logic [DIV_W-1:0] ratio_i,
  output logic [DIV_W-1:0] cnt_o,
  output logic [DIV_W-1:0] ratio_o,
  output logic             q_o
);
  localparam logic [DIV_W-1:0] MinR = DIV_W'(sg_pkg::MIN_DIV);

  logic [DIV_W-1:0] cnt_q, ratio_q, ratio_eff, ratio_new;

  assign ratio_new = (ratio_i < MinR) ? MinR : ratio_i;
  assign ratio_eff = load_i ? ratio_new : ratio_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q   <= '0;
      ratio_q <= MinR;
    end else begin
      ratio_q <= ratio_eff;
      cnt_q   <= (cnt_q == ratio_eff - DIV_W'(1)) ? '0 : cnt_q + DIV_W'(1);
    end
  end

  assign cnt_o   = cnt_q;
  assign ratio_o = ratio_eff;
  assign q_o     = cnt_q < (ratio_eff >> 1);

  p_cnt_bound_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cnt_o < ratio_o);
  p_ratio_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !load_i |=> $stable(ratio_q));
endmodule

// File: rtl/sg_window.sv
module sg_window #(
  parameter int DIV_W = 6
) (
  input  logic [DIV_W-1:0] cnt_a_i,
  input  logic [DIV_W-1:0] cnt_c_i,
  input  logic [DIV_W-1:0] ratio_a_i,
  input  logic [DIV_W-1:0] ratio_c_i,
  input  logic             alt_i,
  output logic             win_o,
  output logic             equal_o,
  output logic [DIV_W-1:0] fast_cnt_o
);
  logic             a_fast;
  logic [DIV_W-1:0] r_f, r_s, c_f, c_s;
  logic [DIV_W:0]   target;

  always_comb begin
    a_fast  = ratio_a_i < ratio_c_i;
    equal_o = ratio_a_i == ratio_c_i;
    r_f = a_fast ? ratio_a_i : ratio_c_i;
    r_s = a_fast ? ratio_c_i : ratio_a_i;
    c_f = a_fast ? cnt_a_i : cnt_c_i;
    c_s = a_fast ? cnt_c_i : cnt_a_i;
    // slow counter lags the shared edge by exactly what the fast one has left
    target = {1'b0, r_s} - {1'b0, r_f} + {1'b0, c_f};
    win_o  = equal_o ? alt_i : ({1'b0, c_s} == target);
  end

  assign fast_cnt_o = c_f;
endmodule

// File: rtl/coin_sync_gen.sv
module coin_sync_gen #(
  parameter int DIV_W = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [DIV_W-1:0] div_a_i,
  input  logic [DIV_W-1:0] div_c_i,
  input  logic             sync_en_i,
  output logic             qa_o,
  output logic             qc_o,
  output logic             sync_no
);
  localparam int NC = sg_pkg::N_CLK;

  logic [DIV_W-1:0] ratio_in [NC];
  logic [DIV_W-1:0] cnt      [NC];
  logic [DIV_W-1:0] ratio    [NC];
  logic [NC-1:0]    q;
  logic             at_coin, alt_q, alt_eff, en_q, en_eff;
  logic             win, equal;
  logic [DIV_W-1:0] fast_cnt;

  assign ratio_in[0] = div_a_i;
  assign ratio_in[1] = div_c_i;
  assign at_coin = (cnt[0] == '0) && (cnt[1] == '0);

  for (genvar i = 0; i < NC; i++) begin : g_div
    sg_divider #(.DIV_W(DIV_W)) u_div (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .load_i (at_coin),
      .ratio_i(ratio_in[i]),
      .cnt_o  (cnt[i]),
      .ratio_o(ratio[i]),
      .q_o    (q[i])
    );
  end

  sg_window #(.DIV_W(DIV_W)) u_win (
    .cnt_a_i   (cnt[0]),
    .cnt_c_i   (cnt[1]),
    .ratio_a_i (ratio[0]),
    .ratio_c_i (ratio[1]),
    .alt_i     (alt_eff),
    .win_o     (win),
    .equal_o   (equal),
    .fast_cnt_o(fast_cnt)
  );

  // enable and alternation only move on a shared edge, never mid-pulse
  assign alt_eff = at_coin ? ~alt_q : alt_q;
  assign en_eff  = at_coin ? sync_en_i : en_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      alt_q <= 1'b1;
      en_q  <= 1'b0;
    end else begin
      alt_q <= alt_eff;
      en_q  <= en_eff;
    end
  end

  assign qa_o    = q[0];
  assign qc_o    = q[1];
  assign sync_no = ~(en_eff & win);

  p_rise_on_coin_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(sync_no) |-> (at_coin && qa_o && qc_o));
  p_high_at_coin_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (at_coin && !equal) |-> sync_no);
  p_fall_fast_edge_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(sync_no) |-> (fast_cnt == '0));
  p_frozen_high_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!en_q && !at_coin) |-> sync_no);
  p_ratio_sampled_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !at_coin |=> $stable(ratio[0]) || at_coin);
endmodule

// File: tb/coin_sync_gen_bench.sv
module coin_sync_gen_bench;
  localparam int DIV_W = 6;
  localparam time PER = 10ns;

  logic clk = 1'b0;
  logic rst_ni = 1'b0;
  logic [DIV_W-1:0] div_a_i = 6'd4, div_c_i = 6'd4;
  logic sync_en_i = 1'b0;
  logic qa_o, qc_o, sync_no;

  int vectors = 0, misses = 0;
  bit done = 1'b0;

  always #(PER/2) clk = ~clk;

  coin_sync_gen #(.DIV_W(DIV_W)) u_coin_sync_gen (
    .clk_i(clk), .rst_ni(rst_ni), .div_a_i(div_a_i), .div_c_i(div_c_i),
    .sync_en_i(sync_en_i), .qa_o(qa_o), .qc_o(qc_o), .sync_no(sync_no)
  );

  function automatic int clampr(int v);
    return (v < 2) ? 2 : v;
  endfunction

  function automatic int lcm(int x, int y);
    int p = x, r = y, t;
    while (r != 0) begin t = p % r; p = r; r = t; end
    return (x / p) * y;
  endfunction

  task automatic check(string req, logic act, logic exp, string what);
    vectors++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s %s actual=%0b expected=%0b t=%0t", req, what, act, exp, $time);
    end
  endtask

  // behavioural model: phase inside the LCM frame since the last shared edge
  int t = 0, ma = 2, mc = 2, ml = 2, coin = 0;
  bit men = 1'b0;
  logic prev_sync = 1'b1;
  bit started = 1'b0;

  always @(negedge clk) begin
    if (!rst_ni) begin
      t = 0; coin = 0; started = 1'b0;
      check("R7", sync_no, 1'b1, "sync_no in reset");
    end else begin
      bit ea, ec, low, es;
      int mf;
      if (t == 0) begin
        ma = clampr(int'(div_a_i)); mc = clampr(int'(div_c_i));
        men = sync_en_i; ml = lcm(ma, mc); coin++;
      end
      if (!started) begin
        check("R7", qa_o & qc_o, 1'b1, "both clocks high after reset");
        started = 1'b1;
      end
      ea = (t % ma) < (ma / 2);
      ec = (t % mc) < (mc / 2);
      mf = (ma < mc) ? ma : mc;
      if (ma == mc) low = (coin % 2) == 0;
      else          low = t >= ml - mf;
      es = !(men && low);
      check((t != 0 && clampr(int'(div_a_i)) != ma) ? "R5" : "R1", qa_o, ea, "qa_o");
      check((t != 0 && clampr(int'(div_c_i)) != mc) ? "R5" : "R1", qc_o, ec, "qc_o");
      check(!men ? "R6" : (ma == mc) ? "R4" : "R2", sync_no, es, "sync_no");
      if (prev_sync === 1'b0 && sync_no === 1'b1)
        check("R3", (t == 0) ? 1'b1 : 1'b0, 1'b1, "sync rise on shared edge");
      prev_sync = sync_no;
      t++;
      if (t == ml) t = 0;
    end
  end

  task automatic run(int a, int c, int n);
    @(posedge clk); #1;
    div_a_i = DIV_W'(a); div_c_i = DIV_W'(c);
    repeat (n) @(posedge clk);
  endtask

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_ni = 1'b1;
    sync_en_i = 1'b1;
    // R8: listed ratio pairs on both sides, odd and clamped values
    run(4, 4, 60);
    run(8, 4, 97);
    run(12, 4, 133);
    run(12, 8, 151);
    run(16, 4, 77);
    run(16, 12, 211);
    run(24, 4, 149);
    run(4, 24, 163);
    run(3, 5, 121);
    run(1, 2, 40);
    run(6, 6, 55);
    run(9, 6, 101);
    // R6: enable toggled at arbitrary points, including inside pulses
    run(12, 8, 7);
    @(posedge clk); #1 sync_en_i = 1'b0;
    repeat (53) @(posedge clk);
    #1 sync_en_i = 1'b1;
    repeat (29) @(posedge clk);
    #1 sync_en_i = 1'b0;
    repeat (31) @(posedge clk);
    #1 sync_en_i = 1'b1;
    run(5, 5, 45);
    #1 sync_en_i = 1'b0;
    repeat (13) @(posedge clk);
    #1 sync_en_i = 1'b1;
    run(20, 6, 183);
    run(6, 20, 90);
    repeat (5) @(posedge clk);
    done = 1'b1;
    $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      misses++;
      $display("FAIL R1 watchdog actual=hung expected=done");
      $display("  == %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  end
endmodule